// File: doc/BRIEF.md
# Watchdog Timer with Shared Interrupt/Frequency-Test Pin

This block is the watchdog section of a timekeeping controller. A host programs one watchdog register over a simple byte-wide register bus. The register holds three fields: a multiplier, a resolution select and a steering bit. The steering bit decides what happens when the watchdog expires. It either latches an interrupt on a pin that is shared with the alarm interrupt and a frequency-test square wave, or it emits a reset pulse of fixed length and then restarts itself. Time is counted in periods of a 16 Hz tick input.

Each time-out sets a sticky flag in a flags register. Any read of that register clears the flag. A latched interrupt is released only when the host writes zero to the watchdog register, and that write also disarms the timer. A power-fail indication clears the watchdog register and stops the timer. On the shared pin, the watchdog and the alarm always take precedence over the frequency-test wave.

Top module: `wdt_shared_irq`

## Requirements
- R1: The watchdog register at address 0x1FFF7 is laid out as bit 7 = steering (0 selects the shared pin, 1 selects the reset output), bits 6:2 = multiplier M, and bits 1:0 = resolution R. It reads back as written. With M nonzero, the time-out occurs on the (M x 4^R)-th tick after the write, so the step is 1, 4, 16 or 64 ticks for R = 0, 1, 2, 3.
- R2: In pin mode, a time-out drives the shared pin active (high), and the pin stays active through further ticks until 0x00 is written to the watchdog register.
- R3: Writing 0x00 to the watchdog register releases a latched watchdog interrupt and disarms the timer, so no further time-out occurs.
- R4: Any write whose multiplier is nonzero restarts the full time-out period. A write with multiplier zero leaves the watchdog disabled.
- R5: In reset mode, a time-out drives the reset output high for exactly RST_LEN clock cycles, starting in the cycle after the expiring tick. The timer then reloads and expires again after a further full period. The shared pin is not driven by the watchdog in this mode.
- R6: Bit 7 of the flags register at 0x1FFF0 is set on every time-out in either mode. Any read of the flags register clears it, but a time-out in the same cycle as the read leaves it set. Read data shows the value before the read clears it.
- R7: A power-fail input clears the watchdog register to 0x00, stops the timer and releases a latched watchdog interrupt.
- R8: The control register at 0x1FFF1 has bit 0 = frequency-test enable and bit 1 = alarm enable. The frequency-test wave reaches the shared pin only when bit 0 is set, the alarm is not enabled, and the watchdog is not armed (nonzero multiplier) in pin mode. An active watchdog or alarm interrupt always drives the pin.
- R9: With the alarm enabled, an alarm-match pulse sets bit 6 of the flags register, which drives the shared pin active until a flags read clears it. With the alarm disabled, alarm-match pulses have no effect.
- R10: After reset all three registers read 0x00, and both the shared pin and the reset output are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 17 | Register address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tick_i | input | 1 | 16 Hz time-base tick, one cycle wide |
| pfail_i | input | 1 | Power-fail indication |
| alarm_match_i | input | 1 | Alarm match pulse from the calendar |
| ft_wave_i | input | 1 | Frequency-test square wave |
| irq_ft_o | output | 1 | Shared interrupt / frequency-test pin |
| wd_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume that every bus strobe lasts a single cycle, that read and write strobes never occur together, and that the tick is a one-cycle pulse spaced well apart from the others. They also assume power-fail is a short pulse, not a level held across bus accesses. The stimulus tasks drive each strobe, tick and power-fail pulse on a falling edge and remove it on the next falling edge. Bus accesses and ticks are issued one at a time, with one deliberate exception: a tick and a flags read placed in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Bit positions that software decodes
   localparam int FLAG_WD_BIT = 7;
   localparam int FLAG_AL_BIT = 6;
   localparam int CTRL_FT_BIT = 0;
   localparam int CTRL_AL_BIT = 1;

   typedef enum logic {
      STEER_PIN = 1'b0,
      STEER_RST = 1'b1
   } steer_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int WD_W       = 8,
   parameter logic [ADDR_W-1:0] FLAGS_ADDR = 17'h1FFF0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 17'h1FFF1,
   parameter logic [ADDR_W-1:0] WD_ADDR    = 17'h1FFF7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic              pfail_i,
   input  logic              timeout_i,
   input  logic              alarm_match_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [WD_W-1:0]   wd_q_o,
   output logic              ft_en_o,
   output logic              al_en_o,
   output logic              wd_flag_o,
   output logic              al_flag_o,
   output logic              wd_wr_o,
   output logic              flags_rd_o
);
   import wdt_pkg::*;

   logic [WD_W-1:0] wd_q;
   logic            ft_en_q, al_en_q, wd_flag_q, al_flag_q;
   logic            sel_flags, sel_ctrl, sel_wd;

   assign sel_flags  = (addr_i == FLAGS_ADDR);
   assign sel_ctrl   = (addr_i == CTRL_ADDR);
   assign sel_wd     = (addr_i == WD_ADDR);
   assign wd_wr_o    = wr_i && sel_wd;
   assign flags_rd_o = rd_i && sel_flags;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wd_q <= '0;
      end else if (pfail_i) begin
         wd_q <= '0;
      end else if (wd_wr_o) begin
         wd_q <= wdata_i[WD_W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ft_en_q <= 1'b0;
         al_en_q <= 1'b0;
      end else if (wr_i && sel_ctrl) begin
         ft_en_q <= wdata_i[CTRL_FT_BIT];
         al_en_q <= wdata_i[CTRL_AL_BIT];
      end
   end

   // Set beats clear so a same-cycle event is never lost
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wd_flag_q <= 1'b0;
         al_flag_q <= 1'b0;
      end else begin
         if (timeout_i)                    wd_flag_q <= 1'b1;
         else if (flags_rd_o)              wd_flag_q <= 1'b0;
         if (alarm_match_i && al_en_q)     al_flag_q <= 1'b1;
         else if (flags_rd_o)              al_flag_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (sel_flags) begin
         rdata_o[FLAG_WD_BIT] = wd_flag_q;
         rdata_o[FLAG_AL_BIT] = al_flag_q;
      end else if (sel_ctrl) begin
         rdata_o[CTRL_FT_BIT] = ft_en_q;
         rdata_o[CTRL_AL_BIT] = al_en_q;
      end else if (sel_wd) begin
         rdata_o[WD_W-1:0] = wd_q;
      end
   end

   assign wd_q_o    = wd_q;
   assign ft_en_o   = ft_en_q;
   assign al_en_o   = al_en_q;
   assign wd_flag_o = wd_flag_q;
   assign al_flag_o = al_flag_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
   parameter int MULT_W      = 5,
   parameter int RES_W       = 2,
   parameter int RES_SH      = 2,
   parameter int RST_LEN     = 4,
   parameter bit RST_ACT_LOW = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              pfail_i,
   input  logic              wd_wr_i,
   input  logic              new_zero_i,
   input  logic [MULT_W-1:0] new_mult_i,
   input  logic [RES_W-1:0]  new_res_i,
   input  logic [MULT_W-1:0] cur_mult_i,
   input  logic [RES_W-1:0]  cur_res_i,
   input  logic              cur_steer_i,
   output logic              timeout_o,
   output logic              wd_irq_o,
   output logic              rst_act_o,
   output logic              wd_rst_o
);
   import wdt_pkg::*;

   localparam int SH_MAX = RES_SH * ((1 << RES_W) - 1);
   localparam int CNT_W  = MULT_W + SH_MAX;
   localparam int RC_W   = $clog2(RST_LEN + 1);

   logic [CNT_W-1:0] cnt_q, per_new, per_cur;
   logic [RC_W-1:0]  rc_q;
   logic             run_q, irq_q, load, stop, irq_clr;

   assign per_new = CNT_W'(new_mult_i) << (RES_SH * int'(new_res_i));
   assign per_cur = CNT_W'(cur_mult_i) << (RES_SH * int'(cur_res_i));

   assign load    = wd_wr_i && !pfail_i && (new_mult_i != '0);
   assign stop    = pfail_i || (wd_wr_i && (new_mult_i == '0));
   assign irq_clr = pfail_i || (wd_wr_i && new_zero_i);

   assign timeout_o = run_q && tick_i && (cnt_q == CNT_W'(1)) && !wd_wr_i && !pfail_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (stop) begin
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= per_new;
         run_q <= 1'b1;
      end else if (timeout_o) begin
         if (cur_steer_i == STEER_RST) cnt_q <= per_cur;
         else                          run_q <= 1'b0;
      end else if (run_q && tick_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    irq_q <= 1'b0;
      else if (irq_clr)                               irq_q <= 1'b0;
      else if (timeout_o && cur_steer_i == STEER_PIN) irq_q <= 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    rc_q <= '0;
      else if (timeout_o && cur_steer_i == STEER_RST) rc_q <= RC_W'(RST_LEN);
      else if (rc_q != '0)                            rc_q <= rc_q - RC_W'(1);
   end

   assign wd_irq_o  = irq_q;
   assign rst_act_o = (rc_q != '0);

   generate
      if (RST_ACT_LOW) begin : g_rst_low
         assign wd_rst_o = ~rst_act_o;
      end else begin : g_rst_high
         assign wd_rst_o = rst_act_o;
      end
   endgenerate
endmodule

// File: rtl/wdt_pin_mux.sv
module wdt_pin_mux #(
   parameter bit PIN_ACT_LOW = 1'b0
) (
   input  logic wd_irq_i,
   input  logic al_flag_i,
   input  logic ft_en_i,
   input  logic al_en_i,
   input  logic wd_armed_pin_i,
   input  logic ft_wave_i,
   output logic pin_act_o,
   output logic pin_o
);
   logic ft_ok;

   // Watchdog and alarm own the pin whenever either may use it
   assign ft_ok     = ft_en_i && !al_en_i && !wd_armed_pin_i;
   assign pin_act_o = wd_irq_i || al_flag_i || (ft_ok && ft_wave_i);

   generate
      if (PIN_ACT_LOW) begin : g_pin_low
         assign pin_o = ~pin_act_o;
      end else begin : g_pin_high
         assign pin_o = pin_act_o;
      end
   endgenerate
endmodule

// File: rtl/wdt_shared_irq.sv
module wdt_shared_irq #(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int MULT_W      = 5,
   parameter int RES_W       = 2,
   parameter int RES_SH      = 2,
   parameter int RST_LEN     = 4,
   parameter bit PIN_ACT_LOW = 1'b0,
   parameter bit RST_ACT_LOW = 1'b0,
   parameter logic [ADDR_W-1:0] FLAGS_ADDR = 17'h1FFF0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 17'h1FFF1,
   parameter logic [ADDR_W-1:0] WD_ADDR    = 17'h1FFF7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   input  logic              wr_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              tick_i,
   input  logic              pfail_i,
   input  logic              alarm_match_i,
   input  logic              ft_wave_i,
   output logic              irq_ft_o,
   output logic              wd_rst_o
);
   import wdt_pkg::*;

   localparam int WD_W     = 1 + MULT_W + RES_W;
   localparam int STEER_B  = MULT_W + RES_W;

   generate
      if (WD_W > DATA_W) begin : g_bad_width
         $error("watchdog fields exceed data width");
      end
      if (DATA_W <= FLAG_WD_BIT) begin : g_bad_flags
         $error("data width too small for flags");
      end
      if (RST_LEN < 1 || MULT_W < 1 || RES_W < 1) begin : g_bad_param
         $error("RST_LEN, MULT_W and RES_W must be at least 1");
      end
   endgenerate

   logic [WD_W-1:0] wd_q;
   logic            ft_en, al_en, wd_flag, al_flag, wd_wr, flags_rd;
   logic            timeout, wd_irq, rst_act, pin_act, wd_armed_pin;

   wdt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WD_W(WD_W),
      .FLAGS_ADDR(FLAGS_ADDR), .CTRL_ADDR(CTRL_ADDR), .WD_ADDR(WD_ADDR)
   ) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
      .rd_i(rd_i), .wr_i(wr_i), .pfail_i(pfail_i), .timeout_i(timeout),
      .alarm_match_i(alarm_match_i), .rdata_o(rdata_o), .wd_q_o(wd_q),
      .ft_en_o(ft_en), .al_en_o(al_en), .wd_flag_o(wd_flag),
      .al_flag_o(al_flag), .wd_wr_o(wd_wr), .flags_rd_o(flags_rd)
   );

   wdt_timer #(
      .MULT_W(MULT_W), .RES_W(RES_W), .RES_SH(RES_SH),
      .RST_LEN(RST_LEN), .RST_ACT_LOW(RST_ACT_LOW)
   ) timer_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pfail_i(pfail_i),
      .wd_wr_i(wd_wr), .new_zero_i(wdata_i == '0),
      .new_mult_i(wdata_i[RES_W +: MULT_W]), .new_res_i(wdata_i[RES_W-1:0]),
      .cur_mult_i(wd_q[RES_W +: MULT_W]), .cur_res_i(wd_q[RES_W-1:0]),
      .cur_steer_i(wd_q[STEER_B]), .timeout_o(timeout), .wd_irq_o(wd_irq),
      .rst_act_o(rst_act), .wd_rst_o(wd_rst_o)
   );

   assign wd_armed_pin = (wd_q[RES_W +: MULT_W] != '0) && (wd_q[STEER_B] == STEER_PIN);

   wdt_pin_mux #(.PIN_ACT_LOW(PIN_ACT_LOW)) mux_i (
      .wd_irq_i(wd_irq), .al_flag_i(al_flag), .ft_en_i(ft_en), .al_en_i(al_en),
      .wd_armed_pin_i(wd_armed_pin), .ft_wave_i(ft_wave_i),
      .pin_act_o(pin_act), .pin_o(irq_ft_o)
   );
endmodule

// File: rtl/wdt_shared_irq_chk.sv
module wdt_shared_irq_chk #(
   parameter int WD_W        = 8,
   parameter int DATA_W      = 8,
   parameter bit PIN_ACT_LOW = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wd_wr,
   input logic [DATA_W-1:0] wdata_i,
   input logic              pfail_i,
   input logic              wd_irq,
   input logic [WD_W-1:0]   wd_q,
   input logic              timeout,
   input logic              flags_rd,
   input logic              wd_flag,
   input logic              al_flag,
   input logic              rst_act,
   input logic              irq_ft_o
);
   assert_irq_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_irq && !pfail_i && !(wd_wr && wdata_i == '0)) |=> wd_irq);

   assert_zero_disarm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_wr && wdata_i == '0) |=> (!wd_irq && !timeout));

   assert_rst_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_act) |-> $past(timeout));

   assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout |=> wd_flag);

   assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_rd && !timeout) |=> !wd_flag);

   assert_pfail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pfail_i |=> (wd_q == '0 && !wd_irq));

   assert_pin_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_irq || al_flag) |-> (irq_ft_o == !PIN_ACT_LOW));
endmodule

bind wdt_shared_irq wdt_shared_irq_chk #(
   .WD_W(WD_W), .DATA_W(DATA_W), .PIN_ACT_LOW(PIN_ACT_LOW)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .wd_wr(wd_wr), .wdata_i(wdata_i),
   .pfail_i(pfail_i), .wd_irq(wd_irq), .wd_q(wd_q), .timeout(timeout),
   .flags_rd(flags_rd), .wd_flag(wd_flag), .al_flag(al_flag),
   .rst_act(rst_act), .irq_ft_o(irq_ft_o)
);

// File: tb/wdt_shared_irq_tb_top.sv
`timescale 1ns/1ps
module wdt_shared_irq_tb_top;
   localparam int RST_LEN = 4;
   localparam logic [16:0] A_FLAGS = 17'h1FFF0;
   localparam logic [16:0] A_CTRL  = 17'h1FFF1;
   localparam logic [16:0] A_WD    = 17'h1FFF7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        rd = 1'b0, wr = 1'b0, tick = 1'b0, pfail = 1'b0;
   logic        amatch = 1'b0, ftw = 1'b0;
   logic [7:0]  rdata;
   logic        pin, wrst;
   int          n_run = 0, n_fail = 0;
   logic        done = 1'b0;

   always #2 clk = ~clk;

   wdt_shared_irq #(.RST_LEN(RST_LEN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
      .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .tick_i(tick),
      .pfail_i(pfail), .alarm_match_i(amatch), .ft_wave_i(ftw),
      .irq_ft_o(pin), .wd_rst_o(wrst)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [16:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_rd(A_FLAGS, d); chk("R10 flags", d, 0);
      bus_rd(A_CTRL, d);  chk("R10 ctrl", d, 0);
      bus_rd(A_WD, d);    chk("R10 wd", d, 0);
      chk("R10 pin", pin, 0);
      chk("R10 rst", wrst, 0);
   endtask

   task automatic t_pin_mode();
      logic [7:0] d;
      bus_wr(A_WD, 8'h0C);               // M=3 R=0 -> 3 ticks
      bus_rd(A_WD, d); chk("R1 readback", d, 8'h0C);
      ticks(2); chk("R1 before period", pin, 0);
      ticks(1); chk("R2 pin at timeout", pin, 1);
      chk("R2 no reset output", wrst, 0);
      bus_rd(A_FLAGS, d); chk("R6 flag set", d, 8'h80);
      bus_rd(A_FLAGS, d); chk("R6 flag cleared by read", d, 0);
      ticks(5); chk("R2 pin held", pin, 1);
      bus_wr(A_WD, 8'h00); #1 chk("R3 pin released", pin, 0);
      ticks(6); chk("R3 disarmed pin", pin, 0);
      bus_rd(A_FLAGS, d); chk("R3 disarmed flag", d, 0);
   endtask

   task automatic t_resolution();
      bus_wr(A_WD, 8'h09);               // M=2 R=1 -> 8 ticks
      ticks(7); chk("R1 res1 before", pin, 0);
      ticks(1); chk("R1 res1 at period", pin, 1);
      bus_wr(A_WD, 8'h06);               // M=1 R=2 -> 16 ticks
      ticks(15); chk("R1 res2 before", pin, 1);
      bus_wr(A_WD, 8'h00);
   endtask

   task automatic t_restart();
      logic [7:0] d;
      bus_wr(A_WD, 8'h0C);
      ticks(2);
      bus_wr(A_WD, 8'h0C);
      ticks(2); chk("R4 restarted not expired", pin, 0);
      ticks(1); chk("R4 restarted expires", pin, 1);
      bus_wr(A_WD, 8'h00);
      bus_rd(A_FLAGS, d);
      bus_wr(A_WD, 8'h01);               // multiplier zero
      ticks(20); chk("R4 mult zero pin", pin, 0);
      bus_rd(A_FLAGS, d); chk("R4 mult zero flag", d, 0);
      bus_wr(A_WD, 8'h00);
   endtask

   task automatic t_reset_mode();
      logic [7:0] d;
      int n;
      bus_wr(A_WD, 8'h88);               // steer reset, M=2 R=0
      ticks(1); chk("R5 before", wrst, 0);
      ticks(1); n = 0;
      while (wrst && n < 50) begin n++; @(negedge clk); end
      chk("R5 pulse length", n, RST_LEN);
      chk("R5 pin idle", pin, 0);
      bus_rd(A_FLAGS, d); chk("R6 flag in reset mode", d, 8'h80);
      ticks(1); chk("R5 reload not yet", wrst, 0);
      ticks(1); chk("R5 reload expires", wrst, 1);
      bus_wr(A_WD, 8'h00);
      bus_rd(A_FLAGS, d);
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      bus_wr(A_WD, 8'h84);               // reset mode, 1 tick
      @(negedge clk); tick = 1'b1; addr = A_FLAGS; rd = 1'b1;
      @(negedge clk); tick = 1'b0; rd = 1'b0;
      bus_rd(A_FLAGS, d); chk("R6 read+timeout keeps flag", d, 8'h80);
      bus_wr(A_WD, 8'h00);
      repeat (RST_LEN + 2) @(negedge clk);
      bus_rd(A_FLAGS, d); chk("R6 cleared afterwards", d, 0);
   endtask

   task automatic t_pfail();
      logic [7:0] d;
      bus_wr(A_WD, 8'h0C);
      @(negedge clk); pfail = 1'b1; @(negedge clk); pfail = 1'b0;
      bus_rd(A_WD, d); chk("R7 register cleared", d, 0);
      ticks(6); chk("R7 timer stopped", pin, 0);
      bus_wr(A_WD, 8'h04);
      ticks(1); chk("R7 setup irq", pin, 1);
      @(negedge clk); pfail = 1'b1; @(negedge clk); pfail = 1'b0;
      chk("R7 irq released", pin, 0);
      bus_rd(A_FLAGS, d);
   endtask

   task automatic t_priority();
      bus_wr(A_CTRL, 8'h01);
      ftw = 1'b1; #1 chk("R8 ft passes high", pin, 1);
      ftw = 1'b0; #1 chk("R8 ft passes low", pin, 0);
      bus_wr(A_WD, 8'h0C);
      ftw = 1'b1; #1 chk("R8 armed watchdog suppresses ft", pin, 0);
      bus_wr(A_WD, 8'h8C); #1 chk("R8 reset mode allows ft", pin, 1);
      bus_wr(A_WD, 8'h00);
      bus_wr(A_CTRL, 8'h03); #1 chk("R8 alarm enable suppresses ft", pin, 0);
      ftw = 1'b0;
   endtask

   task automatic t_alarm();
      logic [7:0] d;
      bus_wr(A_CTRL, 8'h00);
      @(negedge clk); amatch = 1'b1; @(negedge clk); amatch = 1'b0;
      chk("R9 disabled alarm pin", pin, 0);
      bus_rd(A_FLAGS, d); chk("R9 disabled alarm flag", d, 0);
      bus_wr(A_CTRL, 8'h02);
      @(negedge clk); amatch = 1'b1; @(negedge clk); amatch = 1'b0;
      chk("R9 alarm pin", pin, 1);
      bus_rd(A_FLAGS, d); chk("R9 alarm flag", d, 8'h40);
      chk("R9 pin after read", pin, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_pin_mode();
            t_resolution();
            t_restart();
            t_reset_mode();
            t_same_cycle();
            t_pfail();
            t_priority();
            t_alarm();
         end
         begin
            repeat (100000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule